// File: doc/BRIEF.md
# Two-Beat Burst SRAM Command Sequencer

This block sits on the host side of a double-data-rate burst SRAM. Each word of the SRAM is moved as a pair of half-cycle beats. The block accepts a stream of requests under a valid/ready handshake. Each request carries a read/write flag, an address, two data words and per-beat byte enables. The block turns each accepted request into one command cycle on the SRAM control pins. It registers the command pins, so a command appears in the cycle after the request is accepted. Write data follows the command by one cycle: beat A is meant for the rising-edge transfer and beat B for the falling-edge transfer of that cycle.

Two rules apply to the order of commands. A write never follows a read without idle cycles in between. The number of idle cycles is one, or two when `gapTwo` is high. Every other pairing of commands may run back to back. The block holds off a write request with `reqReady` low until enough idle cycles have passed. Read requests are never held off.

Read data from the device is sampled at a fixed cycle offset. The offset depends on whether the device runs with the short (one-cycle) or the long (one-and-a-half-cycle) read latency. Each read request returns both words on the response port with a single-cycle valid pulse. Responses come back in request order.

Top module: `sram_burst_seq`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `sramLdN` and `sramRwN` are 1, `sramAddr` is 0, both byte-select buses are all ones, `rspValid` is 0 and `reqReady` is 1.
- R2: A read request accepted at a rising edge (`reqValid` and `reqReady` high, `reqWrite` 0) produces, in the following cycle, `sramLdN`=0, `sramRwN`=1 and `sramAddr` equal to the request address.
- R3: An accepted write request (`reqWrite` 1) produces, in the following cycle, `sramLdN`=0, `sramRwN`=0 and `sramAddr` equal to the request address.
- R4: In a cycle that follows an edge with no accepted request, `sramLdN` and `sramRwN` are 1 and `sramAddr` is 0.
- R5: In the cycle after a write command cycle, `sramWdA`/`sramWdB` carry the request's first/second word and `sramBwAN`/`sramBwBN` are the bitwise inverse of `reqBeA`/`reqBeB` (active low, bit i selects lane i). In every other cycle both byte-select buses are all ones and both data buses are 0.
- R6: With `gapTwo`=0, a write command cycle never directly follows a read command cycle. A write that is presented right after a read gets exactly one idle cycle in between.
- R7: With `gapTwo`=1, neither of the two cycles before a write command cycle is a read command cycle. A write that is presented right after a read gets exactly two idle cycles in between.
- R8: Read-to-read, write-to-read and write-to-write transitions take no idle cycle when requests are presented back to back. A read or write placed after enough idle cycles is not delayed further.
- R9: With `latSlow`=0, the words on `sramQA`/`sramQB` during the cycle after a read command cycle appear on `rspWdA`/`rspWdB` with `rspValid`=1 two cycles after the command cycle.
- R10: With `latSlow`=1, the words on `sramQA`/`sramQB` during the second cycle after a read command cycle appear with `rspValid`=1 three cycles after the command cycle.
- R11: `rspValid` is high for exactly one cycle per read command, and responses appear in the order the reads were accepted.
- R12: `reqReady` is low only while a write request is presented inside the read-to-write window. A presented read request always sees `reqReady`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| gapTwo | input | 1 | 1: two idle cycles on read-to-write, 0: one |
| latSlow | input | 1 | 1: long device read latency, 0: short |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request taken at this edge when valid |
| reqWrite | input | 1 | 1: write request, 0: read request |
| reqAddr | input | ADDR_W | Request burst address |
| reqWdA | input | DATA_W | Write word for beat A |
| reqWdB | input | DATA_W | Write word for beat B |
| reqBeA | input | LANES | Byte enables for beat A, active high |
| reqBeB | input | LANES | Byte enables for beat B, active high |
| rspValid | output | 1 | One-cycle pulse with read response |
| rspWdA | output | DATA_W | First returned word |
| rspWdB | output | DATA_W | Second returned word |
| sramLdN | output | 1 | Load strobe, active low |
| sramRwN | output | 1 | 1: read, 0: write |
| sramAddr | output | ADDR_W | Command address |
| sramWdA | output | DATA_W | Write data, rising-edge beat |
| sramWdB | output | DATA_W | Write data, falling-edge beat |
| sramBwAN | output | LANES | Byte selects for beat A, active low |
| sramBwBN | output | LANES | Byte selects for beat B, active low |
| sramQA | input | DATA_W | Device read word, first beat |
| sramQB | input | DATA_W | Device read word, second beat |

## Verification
Several events can land in the same cycle: the data phase of a write, the command cycle of a later request, and the response to an earlier read. The clearest case is the long-latency mode. A read is followed by a write after the turnaround gap, so the write's data beats and the read's response fall in one cycle. Back-to-back write, write, read sequences also put a write's data phase alongside a read command. The bench keeps its own record of command cycles and drives the device read words only in the cycle where the selected latency says they are valid. It compares every pin on every clock, so a capture in the wrong cycle, or data that leaks between the two paths, shows up as a mismatch.

// File: rtl/sram_burst_seq_pkg.sv
package sram_burst_seq_pkg;

  // Strobes passed from the control half to the datapath half each cycle.
  typedef struct packed {
    logic issueRead;   // a read is taken at this edge
    logic issueWrite;  // a write is taken at this edge
    logic driveData;   // the current bus cycle is a write command
    logic capture;     // device read words are valid this cycle
  } seqStrobe_t;

endpackage

// File: rtl/sram_burst_seq_ctrl.sv
module sram_burst_seq_ctrl
  import sram_burst_seq_pkg::*;
#(
  parameter int MAX_GAP = 2,
  parameter int LAT_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       gapTwo,
  input  logic       latSlow,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output seqStrobe_t strobe
);

  localparam int AGE_W = $clog2(MAX_GAP + 2);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(MAX_GAP + 1);

  // Number of bus cycles since the last read command cycle (0 = read now).
  logic [AGE_W-1:0] rdAge;
  logic [AGE_W-1:0] needGap;
  logic             writeBlocked;
  logic             accept;
  logic             busRead;
  logic             busWrite;
  logic [LAT_STAGES-1:0] rdPipe;

  assign needGap      = gapTwo ? AGE_W'(2) : AGE_W'(1);
  assign writeBlocked = rdAge < needGap;
  assign reqReady     = !(reqWrite && writeBlocked);
  assign accept       = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAge    <= AGE_MAX;
      busRead  <= 1'b0;
      busWrite <= 1'b0;
    end else begin
      busRead  <= accept && !reqWrite;
      busWrite <= accept && reqWrite;
      if (accept && !reqWrite)
        rdAge <= '0;
      else if (rdAge != AGE_MAX)
        rdAge <= rdAge + AGE_W'(1);
    end
  end

  // Read-tag delay line: stage k is high k+1 cycles after a read command cycle.
  generate
    for (genvar s = 0; s < LAT_STAGES; s++) begin : g_lat
      always_ff @(posedge clk) begin
        if (!rstN)
          rdPipe[s] <= 1'b0;
        else if (s == 0)
          rdPipe[s] <= busRead;
        else
          rdPipe[s] <= rdPipe[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  always_comb begin
    strobe            = '0;
    strobe.issueRead  = accept && !reqWrite;
    strobe.issueWrite = accept && reqWrite;
    strobe.driveData  = busWrite;
    strobe.capture    = latSlow ? rdPipe[LAT_STAGES-1] : rdPipe[0];
  end

endmodule

// File: rtl/sram_burst_seq_dp.sv
module sram_burst_seq_dp
  import sram_burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdA,
  input  logic [DATA_W-1:0] reqWdB,
  input  logic [LANES-1:0]  reqBeA,
  input  logic [LANES-1:0]  reqBeB,
  input  logic [DATA_W-1:0] sramQA,
  input  logic [DATA_W-1:0] sramQB,
  output logic              sramLdN,
  output logic              sramRwN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramWdA,
  output logic [DATA_W-1:0] sramWdB,
  output logic [LANES-1:0]  sramBwAN,
  output logic [LANES-1:0]  sramBwBN,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspWdA,
  output logic [DATA_W-1:0] rspWdB
);

  logic [DATA_W-1:0] holdWdA;
  logic [DATA_W-1:0] holdWdB;
  logic [LANES-1:0]  holdBeA;
  logic [LANES-1:0]  holdBeB;
  logic              issueAny;

  assign issueAny = strobe.issueRead || strobe.issueWrite;

  // Command pins.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sramLdN  <= 1'b1;
      sramRwN  <= 1'b1;
      sramAddr <= '0;
    end else begin
      sramLdN  <= !issueAny;
      sramRwN  <= !strobe.issueWrite;
      sramAddr <= issueAny ? reqAddr : '0;
    end
  end

  // Write payload held for one cycle, then driven in the data phase.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdWdA <= '0;
      holdWdB <= '0;
      holdBeA <= '0;
      holdBeB <= '0;
    end else if (strobe.issueWrite) begin
      holdWdA <= reqWdA;
      holdWdB <= reqWdB;
      holdBeA <= reqBeA;
      holdBeB <= reqBeB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sramWdA <= '0;
      sramWdB <= '0;
    end else begin
      sramWdA <= strobe.driveData ? holdWdA : '0;
      sramWdB <= strobe.driveData ? holdWdB : '0;
    end
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sramBwAN[i] <= 1'b1;
          sramBwBN[i] <= 1'b1;
        end else begin
          sramBwAN[i] <= !(strobe.driveData && holdBeA[i]);
          sramBwBN[i] <= !(strobe.driveData && holdBeB[i]);
        end
      end
    end
  endgenerate

  // Read response capture.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspWdA   <= '0;
      rspWdB   <= '0;
    end else begin
      rspValid <= strobe.capture;
      if (strobe.capture) begin
        rspWdA <= sramQA;
        rspWdB <= sramQB;
      end
    end
  end

endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gapTwo,
  input  logic              latSlow,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdA,
  input  logic [DATA_W-1:0] reqWdB,
  input  logic [LANES-1:0]  reqBeA,
  input  logic [LANES-1:0]  reqBeB,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspWdA,
  output logic [DATA_W-1:0] rspWdB,
  output logic              sramLdN,
  output logic              sramRwN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramWdA,
  output logic [DATA_W-1:0] sramWdB,
  output logic [LANES-1:0]  sramBwAN,
  output logic [LANES-1:0]  sramBwBN,
  input  logic [DATA_W-1:0] sramQA,
  input  logic [DATA_W-1:0] sramQB
);

  seqStrobe_t strobe;

  sram_burst_seq_ctrl #(
    .MAX_GAP   (2),
    .LAT_STAGES(2)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .gapTwo  (gapTwo),
    .latSlow (latSlow),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobe  (strobe)
  );

  sram_burst_seq_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdA  (reqWdA),
    .reqWdB  (reqWdB),
    .reqBeA  (reqBeA),
    .reqBeB  (reqBeB),
    .sramQA  (sramQA),
    .sramQB  (sramQB),
    .sramLdN (sramLdN),
    .sramRwN (sramRwN),
    .sramAddr(sramAddr),
    .sramWdA (sramWdA),
    .sramWdB (sramWdB),
    .sramBwAN(sramBwAN),
    .sramBwBN(sramBwBN),
    .rspValid(rspValid),
    .rspWdA  (rspWdA),
    .rspWdB  (rspWdB)
  );

endmodule

// File: rtl/sram_burst_seq_chk.sv
module sram_burst_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              gapTwo,
  input logic              latSlow,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              sramLdN,
  input logic              sramRwN,
  input logic [ADDR_W-1:0] sramAddr,
  input logic [LANES-1:0]  sramBwAN,
  input logic [LANES-1:0]  sramBwBN
);

  logic busRd;
  logic busWr;
  assign busRd = !sramLdN && sramRwN;
  assign busWr = !sramLdN && !sramRwN;

  assert_read_issue_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> (busRd && sramAddr == $past(reqAddr)));

  assert_write_issue_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> (busWr && sramAddr == $past(reqAddr)));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> (sramLdN && sramAddr == '0));

  assert_bw_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busWr) |-> (&sramBwAN && &sramBwBN));

  assert_gap_one_R6: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> !$past(busRd));

  assert_gap_two_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && gapTwo && $past(gapTwo)) |-> !$past(busRd, 2));

  assert_lat_short_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busRd, 2) && !latSlow && !$past(latSlow) && !$past(latSlow, 2)) |-> rspValid);

  assert_lat_long_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busRd, 3) && latSlow && $past(latSlow) && $past(latSlow, 2)) |-> rspValid);

  assert_read_ready_R12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |-> reqReady);

endmodule

bind sram_burst_seq sram_burst_seq_chk #(
  .ADDR_W(ADDR_W),
  .LANES (LANES)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .gapTwo  (gapTwo),
  .latSlow (latSlow),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqWrite(reqWrite),
  .reqAddr (reqAddr),
  .rspValid(rspValid),
  .sramLdN (sramLdN),
  .sramRwN (sramRwN),
  .sramAddr(sramAddr),
  .sramBwAN(sramBwAN),
  .sramBwBN(sramBwBN)
);

// File: tb/sram_burst_seq_bench.sv
module sram_burst_seq_bench;

  localparam int AW = 20;
  localparam int DW = 18;
  localparam int LN = 2;
  localparam int HN = 4096;

  logic clk = 1'b0;
  logic rstN, gapTwo, latSlow, reqValid, reqReady, reqWrite;
  logic [AW-1:0] reqAddr, sramAddr;
  logic [DW-1:0] reqWdA, reqWdB, rspWdA, rspWdB, sramWdA, sramWdB, sramQA, sramQB;
  logic [LN-1:0] reqBeA, reqBeB, sramBwAN, sramBwBN;
  logic rspValid, sramLdN, sramRwN;

  always #5 clk = ~clk;

  sram_burst_seq u_sram_burst_seq (
    .clk(clk), .rstN(rstN), .gapTwo(gapTwo), .latSlow(latSlow),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdA(reqWdA), .reqWdB(reqWdB),
    .reqBeA(reqBeA), .reqBeB(reqBeB),
    .rspValid(rspValid), .rspWdA(rspWdA), .rspWdB(rspWdB),
    .sramLdN(sramLdN), .sramRwN(sramRwN), .sramAddr(sramAddr),
    .sramWdA(sramWdA), .sramWdB(sramWdB),
    .sramBwAN(sramBwAN), .sramBwBN(sramBwBN),
    .sramQA(sramQA), .sramQB(sramQB)
  );

  typedef struct packed {
    logic [1:0]    kind;   // 0 bubble, 1 read, 2 write
    logic [AW-1:0] addr;
    logic [DW-1:0] da;
    logic [DW-1:0] db;
    logic [LN-1:0] ba;
    logic [LN-1:0] bb;
  } stim_t;

  stim_t sq[$];
  int nRun = 0;
  int nFail = 0;
  int cyc = 4;
  bit done = 0;

  // Bus history: command kind visible in each bench cycle.
  int            hk[HN];
  logic [AW-1:0] hA[HN];
  logic [DW-1:0] hDa[HN];
  logic [DW-1:0] hDb[HN];
  logic [LN-1:0] hBa[HN];
  logic [LN-1:0] hBb[HN];
  int            readIssue[$];  // cycles of read commands, oldest first

  function automatic logic [DW-1:0] devA(input logic [AW-1:0] a);
    return DW'(a) ^ 18'h05A5A;
  endfunction
  function automatic logic [DW-1:0] devB(input logic [AW-1:0] a);
    return DW'(a) ^ 18'h0C3C3;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic push(input int k, input int a, input int da, input int db, input int ba, input int bb);
    stim_t s;
    s.kind = 2'(k); s.addr = AW'(a); s.da = DW'(da); s.db = DW'(db);
    s.ba = LN'(ba); s.bb = LN'(bb);
    sq.push_back(s);
  endtask

  // One clock: check outputs against the model, drive device and request.
  task automatic step();
    int lat;
    bit expRdy;
    @(posedge clk);
    cyc++;
    @(negedge clk);
    // Command pins (R2, R3, R4)
    if (hk[cyc] == 1)
      chk(!sramLdN && sramRwN && sramAddr == hA[cyc], "R2 read cmd",
          {sramLdN, sramRwN, sramAddr}, {2'b01, hA[cyc]});
    else if (hk[cyc] == 2)
      chk(!sramLdN && !sramRwN && sramAddr == hA[cyc], "R3 write cmd",
          {sramLdN, sramRwN, sramAddr}, {2'b00, hA[cyc]});
    else
      chk(sramLdN && sramRwN && sramAddr == '0, "R4 idle",
          {sramLdN, sramRwN, sramAddr}, {2'b11, {AW{1'b0}}});
    // Write data phase (R5)
    if (hk[cyc-1] == 2)
      chk(sramWdA == hDa[cyc-1] && sramWdB == hDb[cyc-1] &&
          sramBwAN == ~hBa[cyc-1] && sramBwBN == ~hBb[cyc-1], "R5 data phase",
          {sramWdA, sramWdB, sramBwAN, sramBwBN},
          {hDa[cyc-1], hDb[cyc-1], ~hBa[cyc-1], ~hBb[cyc-1]});
    else
      chk(sramWdA == '0 && sramWdB == '0 && &sramBwAN && &sramBwBN, "R5 quiet",
          {sramWdA, sramWdB, sramBwAN, sramBwBN}, {{2*DW{1'b0}}, {2*LN{1'b1}}});
    // Response (R9, R10, R11)
    lat = latSlow ? 3 : 2;
    if (hk[cyc-lat] == 1) begin
      int oldest;
      oldest = (readIssue.size() > 0) ? readIssue.pop_front() : -1;
      chk(rspValid && oldest == cyc - lat && rspWdA == devA(hA[cyc-lat]) &&
          rspWdB == devB(hA[cyc-lat]),
          latSlow ? "R10 R11 long-latency response" : "R9 R11 short-latency response",
          {rspValid, rspWdA, rspWdB}, {1'b1, devA(hA[cyc-lat]), devB(hA[cyc-lat])});
    end else
      chk(!rspValid, "R11 no response", 64'(rspValid), 64'(0));
    // Device model: read words valid only in the cycle set by the latency mode.
    if (hk[cyc-1-(latSlow ? 1 : 0)] == 1) begin
      sramQA = devA(hA[cyc-1-(latSlow ? 1 : 0)]);
      sramQB = devB(hA[cyc-1-(latSlow ? 1 : 0)]);
    end else begin
      sramQA = '1;
      sramQB = '1;
    end
    // Next request
    hk[cyc+1] = 0;
    if (sq.size() > 0 && sq[0].kind == 0) begin
      void'(sq.pop_front());
      reqValid = 1'b0;
    end else if (sq.size() > 0) begin
      reqValid = 1'b1;
      reqWrite = (sq[0].kind == 2);
      reqAddr = sq[0].addr; reqWdA = sq[0].da; reqWdB = sq[0].db;
      reqBeA = sq[0].ba; reqBeB = sq[0].bb;
      #1;
      if (sq[0].kind == 2)
        expRdy = (hk[cyc] != 1) && !(gapTwo && hk[cyc-1] == 1);
      else
        expRdy = 1'b1;
      chk(reqReady == expRdy, sq[0].kind == 2 ? "R6 R7 R8 write ready" : "R12 read ready",
          64'(reqReady), 64'(expRdy));
      if (reqReady) begin
        hk[cyc+1] = sq[0].kind;
        hA[cyc+1] = sq[0].addr; hDa[cyc+1] = sq[0].da; hDb[cyc+1] = sq[0].db;
        hBa[cyc+1] = sq[0].ba; hBb[cyc+1] = sq[0].bb;
        if (sq[0].kind == 1) readIssue.push_back(cyc + 1);
        void'(sq.pop_front());
      end
    end else begin
      reqValid = 1'b0;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drain();
    int g;
    g = 0;
    while (sq.size() > 0 && g < 500) begin step(); g++; end
    run(6);
  endtask

  initial begin
    for (int i = 0; i < HN; i++) hk[i] = 0;
    rstN = 1'b0; gapTwo = 1'b0; latSlow = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    reqAddr = '0; reqWdA = '0; reqWdB = '0; reqBeA = '0; reqBeB = '0;
    sramQA = '1; sramQB = '1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(sramLdN && sramRwN && sramAddr == '0 && !rspValid && &sramBwAN && &sramBwBN && reqReady,
        "R1 reset state", {sramLdN, sramRwN, rspValid, sramBwAN, sramBwBN, reqReady},
        {1'b1, 1'b1, 1'b0, {2*LN{1'b1}}, 1'b1});
    rstN = 1'b1;

    // Phase A: single gap, short latency.
    push(2, 'h10, 'h11111, 'h22222, 2'b11, 2'b11);
    push(2, 'h11, 'h01234, 'h04321, 2'b01, 2'b10);  // R8 write-write
    push(1, 'h10, 0, 0, 0, 0);                      // R8 write-read
    push(1, 'h12, 0, 0, 0, 0);                      // R8 read-read
    push(2, 'h13, 'h0AAAA, 'h15555, 2'b10, 2'b00);  // R6 one NOP
    push(1, 'h14, 0, 0, 0, 0);
    push(0, 0, 0, 0, 0, 0);
    push(2, 'h15, 'h00F0F, 'h3F0F0, 2'b11, 2'b01);  // R8 gap already met
    push(1, 'h16, 0, 0, 0, 0);
    drain();

    // Phase B: double gap, short latency.
    gapTwo = 1'b1;
    run(2);
    push(1, 'h20, 0, 0, 0, 0);
    push(2, 'h21, 'h12345, 'h23456, 2'b11, 2'b11);  // R7 two NOPs
    push(1, 'h22, 0, 0, 0, 0);
    push(0, 0, 0, 0, 0, 0);
    push(2, 'h23, 'h00001, 'h00002, 2'b01, 2'b01);  // R7 one more NOP
    push(1, 'h24, 0, 0, 0, 0);
    push(0, 0, 0, 0, 0, 0);
    push(0, 0, 0, 0, 0, 0);
    push(2, 'h25, 'h30303, 'h03030, 2'b10, 2'b11);  // R7 no extra wait
    push(2, 'h26, 'h11223, 'h33221, 2'b00, 2'b11);
    push(1, 'h27, 0, 0, 0, 0);
    drain();

    // Phase C: single gap, long latency.
    gapTwo = 1'b0; latSlow = 1'b1;
    run(2);
    push(1, 'h30, 0, 0, 0, 0);
    push(1, 'h31, 0, 0, 0, 0);
    push(1, 'h32, 0, 0, 0, 0);
    push(2, 'h33, 'h2468A, 'h13579, 2'b11, 2'b10);  // data phase meets R10 response
    push(1, 'h34, 0, 0, 0, 0);
    push(2, 'h35, 'h0BEEF, 'h0CAFE, 2'b01, 2'b11);
    push(2, 'h36, 'h1F00D, 'h0FACE, 2'b11, 2'b11);
    push(1, 'h37, 0, 0, 0, 0);
    drain();

    // Phase D: double gap, long latency.
    gapTwo = 1'b1;
    run(2);
    push(1, 'h40, 0, 0, 0, 0);
    push(2, 'h41, 'h0ABCD, 'h0DCBA, 2'b11, 2'b01);
    push(1, 'h42, 0, 0, 0, 0);
    push(1, 'h43, 0, 0, 0, 0);
    push(2, 'h44, 'h01111, 'h02222, 2'b10, 2'b10);
    drain();

    chk(readIssue.size() == 0, "R11 every read answered", 64'(readIssue.size()), 64'(0));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog expired at cycle %0d actual=hung expected=finished", cyc);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule